// File: doc/BRIEF.md
# Motor Lock Protection Timer

This block watches the three Hall sensor levels of a brushless motor and decides that the rotor has stalled when none of them has changed for a whole lock window. On a stall it asks the driver stage to turn all outputs off, and it reports a lock status. The drive-off request holds for a fixed off period. The block then returns to service by itself and gives the motor one fresh window in which to show rotation. If no Hall change arrives in that window, it locks again. The whole function runs only while a speed-command flag says that the requested duty is above the minimum-duty threshold.

A prescaler turns the system clock into a slow tick. The lock window and the off period are parameters counted in ticks, so a simulation can use short values. The prescaler and the counter that is running restart on every state change, and the window counter also restarts on every Hall change. This makes each interval exact to the clock cycle. The controller has three states. ST_MONITOR is the normal watch. ST_LOCKED_OFF is the forced-off period. ST_RESTART is the single retry window after an off period.

The transitions are:
- ST_MONITOR to ST_LOCKED_OFF when the window expires with no Hall change.
- ST_LOCKED_OFF to ST_RESTART when the off period expires.
- ST_RESTART to ST_MONITOR on a Hall change.
- ST_RESTART to ST_LOCKED_OFF when the retry window expires.
- Any state to ST_MONITOR, with every counter cleared, while the speed flag is low.

Top module: `mlp_lock_timer`

## Requirements
- R1: With `speed_ok` high and no change on `hall_in`, `drive_off` rises WIN_TICKS*TICK_DIV+1 clock edges after the last clock edge at which a change of `hall_in` was seen.
- R2: Once `drive_off` has risen, it stays high for exactly OFF_TICKS*TICK_DIV+1 clock cycles, provided `speed_ok` stays high.
- R3: When the off period ends, `drive_off` falls with no outside action. If `hall_in` then stays constant, `drive_off` rises again WIN_TICKS*TICK_DIV+1 cycles after it fell.
- R4: `lock_flag` equals `drive_off` on every cycle.
- R5: A rising or a falling transition on any one of the three `hall_in` bits restarts the lock window. Changes spaced closer than the window keep `drive_off` low.
- R6: Changes on `hall_in` while `drive_off` is high have no effect on the length of the off period.
- R7: While `speed_ok` is low, `drive_off` is low from the next clock edge and all timing is cleared. After `speed_ok` rises with `hall_in` constant, `drive_off` rises WIN_TICKS*TICK_DIV+1 cycles later.
- R8: A change of `hall_in` during the retry window returns the block to normal monitoring with a full window measured from that change, the same timing as R1.
- R9: After reset, `drive_off` and `lock_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hall_in | input | 3 | Synchronized Hall sensor levels, one bit per phase |
| speed_ok | input | 1 | High while the speed command is above the minimum-duty threshold |
| drive_off | output | 1 | Request to force all driver outputs low |
| lock_flag | output | 1 | Lock status, high while a lock holds the drive off |

## Verification
The bound checker enforces four properties on every cycle:
- the lock status always equals the drive-off request;
- a low speed flag clears the request by the next edge;
- an off period never lasts longer than its length;
- the request never rises before a full window of Hall silence has passed.

The exact lengths of the window and of the off period, the automatic retry and relock, and the restart of the window on a change of any single line in either direction can only be shown by the bench's directed scenarios. The same holds for ignoring Hall changes during the off period and for the return to monitoring after a change in the retry window. The bench measures each of these in clock cycles.

// File: rtl/mlp_pkg.sv
package mlp_pkg;

    typedef enum logic [1:0] {
        ST_MONITOR    = 2'd0,
        ST_LOCKED_OFF = 2'd1,
        ST_RESTART    = 2'd2
    } mlp_state_e;

endpackage

// File: rtl/mlp_tick_gen.sv
// Prescaler: one-cycle tick every TICK_DIV clocks, restartable.
module mlp_tick_gen #(
    parameter int TICK_DIV = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr || div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = (div_q == LAST) && !clr;

endmodule

// File: rtl/mlp_edge_det.sv
// Change detector across the Hall lines; any bit toggling flags activity.
module mlp_edge_det #(
    parameter int LINES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lvl_in,
    output logic             any_edge
);
    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] chg;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b0;
            end else begin
                prev_q[g] <= lvl_in[g];
            end
        end
        assign chg[g] = lvl_in[g] ^ prev_q[g];
    end

    assign any_edge = |chg;

endmodule

// File: rtl/mlp_tick_cnt.sv
// Saturating tick counter with synchronous clear and terminal flag.
module mlp_tick_cnt #(
    parameter int LIMIT = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == TOP);

endmodule

// File: rtl/mlp_lock_timer.sv
module mlp_lock_timer
    import mlp_pkg::*;
#(
    parameter int TICK_DIV  = 125000,
    parameter int WIN_TICKS = 4000,
    parameter int OFF_TICKS = 20000,
    parameter int HALL_N    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALL_N-1:0] hall_in,
    input  logic              speed_ok,
    output logic              drive_off,
    output logic              lock_flag
);
    mlp_state_e state_q, state_nx;
    logic       hall_edge;
    logic       tick;
    logic       win_done, off_done;
    logic       presc_clr, win_clr, off_clr;
    logic       state_chg;

    mlp_edge_det #(.LINES(HALL_N)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_in   (hall_in),
        .any_edge (hall_edge)
    );

    mlp_tick_gen #(.TICK_DIV(TICK_DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (presc_clr),
        .tick  (tick)
    );

    mlp_tick_cnt #(.LIMIT(WIN_TICKS)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (win_clr),
        .tick  (tick),
        .done  (win_done)
    );

    mlp_tick_cnt #(.LIMIT(OFF_TICKS)) u_off (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (off_clr),
        .tick  (tick),
        .done  (off_done)
    );

    // Next-state decision
    always_comb begin
        state_nx = state_q;
        if (!speed_ok) begin
            state_nx = ST_MONITOR;
        end else begin
            unique case (state_q)
                ST_MONITOR: begin
                    if (win_done && !hall_edge) state_nx = ST_LOCKED_OFF;
                end
                ST_LOCKED_OFF: begin
                    if (off_done) state_nx = ST_RESTART;
                end
                ST_RESTART: begin
                    if (hall_edge)     state_nx = ST_MONITOR;
                    else if (win_done) state_nx = ST_LOCKED_OFF;
                end
                default: state_nx = ST_MONITOR;
            endcase
        end
    end

    assign state_chg = (state_nx != state_q);
    assign presc_clr = !speed_ok || state_chg ||
                       (hall_edge && state_q != ST_LOCKED_OFF);
    assign win_clr   = !speed_ok || hall_edge || state_q == ST_LOCKED_OFF;
    assign off_clr   = !speed_ok || state_q != ST_LOCKED_OFF;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_MONITOR;
        end else begin
            state_q <= state_nx;
        end
    end

    // Outputs
    always_comb begin
        drive_off = 1'b0;
        lock_flag = 1'b0;
        unique case (state_q)
            ST_LOCKED_OFF: begin
                drive_off = 1'b1;
                lock_flag = 1'b1;
            end
            ST_MONITOR, ST_RESTART: begin
                drive_off = 1'b0;
                lock_flag = 1'b0;
            end
            default: begin
                drive_off = 1'b0;
                lock_flag = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mlp_lock_checker.sv
module mlp_lock_checker #(
    parameter int TICK_DIV  = 125000,
    parameter int WIN_TICKS = 4000,
    parameter int OFF_TICKS = 20000,
    parameter int HALL_N    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [HALL_N-1:0] hall_in,
    input logic              speed_ok,
    input logic              drive_off,
    input logic              lock_flag
);
    localparam longint WIN_CYC = longint'(WIN_TICKS) * longint'(TICK_DIV);
    localparam longint OFF_CYC = longint'(OFF_TICKS) * longint'(TICK_DIV) + 1;

    logic [HALL_N-1:0] hall_q;
    longint            quiet_cnt;
    longint            high_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hall_q    <= '0;
            quiet_cnt <= 0;
            high_cnt  <= 0;
        end else begin
            hall_q <= hall_in;
            if (!speed_ok || hall_in != hall_q) quiet_cnt <= 0;
            else if (quiet_cnt < WIN_CYC + 4)   quiet_cnt <= quiet_cnt + 1;
            if (drive_off && high_cnt < OFF_CYC + 4) high_cnt <= high_cnt + 1;
            else if (!drive_off)                     high_cnt <= 0;
        end
    end

    // R4
    lock_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flag == drive_off);

    // R7
    enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !speed_ok |=> !drive_off);

    // R2
    off_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        high_cnt <= OFF_CYC);

    // R1
    quiet_before_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_off) |-> quiet_cnt >= WIN_CYC);

endmodule

bind mlp_lock_timer mlp_lock_checker #(
    .TICK_DIV  (TICK_DIV),
    .WIN_TICKS (WIN_TICKS),
    .OFF_TICKS (OFF_TICKS),
    .HALL_N    (HALL_N)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hall_in   (hall_in),
    .speed_ok  (speed_ok),
    .drive_off (drive_off),
    .lock_flag (lock_flag)
);

// File: tb/mlp_lock_timer_tb.sv
`timescale 1ns/1ps
module mlp_lock_timer_tb;
    localparam int DIV  = 4;
    localparam int WIN  = 5;
    localparam int OFF  = 3;
    localparam int WINC = WIN * DIV;
    localparam int OFFC = OFF * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_in = 3'b000;
    logic       speed_ok = 1'b0;
    logic       drive_off, lock_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mlp_lock_timer #(
        .TICK_DIV(DIV), .WIN_TICKS(WIN), .OFF_TICKS(OFF), .HALL_N(3)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .speed_ok(speed_ok),
        .drive_off(drive_off), .lock_flag(lock_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // From a negedge, count posedges until drive_off is seen high.
    task automatic wait_rise(output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (lock_flag != drive_off) check(0, "R4", lock_flag, drive_off);
        end while (!drive_off && n < 400);
    endtask

    // From a negedge with drive_off high, count high samples (first included).
    task automatic measure_high(output int m, input bit poke);
        m = 1;
        forever begin
            @(negedge clk);
            if (lock_flag != drive_off) check(0, "R4", lock_flag, drive_off);
            if (!drive_off || m > 400) break;
            m++;
            if (poke && (m % 3 == 0)) hall_in = hall_in ^ 3'b010;
        end
    endtask

    task automatic t_reset();
        check(drive_off == 1'b0, "R9", drive_off, 0);
        check(lock_flag == 1'b0, "R9", lock_flag, 0);
    endtask

    task automatic t_window();
        int n;
        @(negedge clk);
        speed_ok = 1'b1;
        hall_in  = 3'b001;
        wait_rise(n);
        check(n == WINC + 2, "R1", n, WINC + 2);
        check(lock_flag == 1'b1, "R4", lock_flag, 1);
    endtask

    task automatic t_offtime();
        int m;
        measure_high(m, 1'b0);
        check(m == OFFC + 1, "R2", m, OFFC + 1);
        check(drive_off == 1'b0, "R3", drive_off, 0);
    endtask

    task automatic t_relock();
        int n;
        wait_rise(n);
        check(n == WINC + 1, "R3", n, WINC + 1);
    endtask

    task automatic t_off_ignore();
        int m;
        measure_high(m, 1'b1);
        check(m == OFFC + 1, "R6", m, OFFC + 1);
    endtask

    task automatic t_restart_edge();
        int n;
        repeat (5) @(negedge clk);
        check(drive_off == 1'b0, "R8", drive_off, 0);
        hall_in = hall_in ^ 3'b100;
        wait_rise(n);
        check(n == WINC + 2, "R8", n, WINC + 2);
    endtask

    task automatic t_disable();
        int n;
        int bad = 0;
        @(negedge clk);
        speed_ok = 1'b0;
        @(negedge clk);
        check(drive_off == 1'b0, "R7", drive_off, 0);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (drive_off) bad++;
        end
        check(bad == 0, "R7", bad, 0);
        speed_ok = 1'b1;
        wait_rise(n);
        check(n == WINC + 1, "R7", n, WINC + 1);
    endtask

    task automatic t_edges_keep();
        int n;
        int bad = 0;
        @(negedge clk);
        speed_ok = 1'b0;
        @(negedge clk);
        speed_ok = 1'b1;
        for (int k = 0; k < 9; k++) begin
            hall_in = hall_in ^ (3'b001 << (k % 3));
            for (int i = 0; i < 15; i++) begin
                @(negedge clk);
                if (drive_off) bad++;
            end
        end
        check(bad == 0, "R5", bad, 0);
        hall_in = hall_in ^ 3'b001;
        wait_rise(n);
        check(n == WINC + 2, "R5", n, WINC + 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_window();
        t_offtime();
        t_relock();
        t_off_ignore();
        t_restart_edge();
        t_disable();
        t_edges_keep();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule